// File: doc/BRIEF.md
# Occupancy-Driven Multithread Fetch Selector

This block decides, every cycle, which hardware threads of a multithreaded front end may fetch and how many fetch slots each of them receives. For every thread it keeps a running count of instructions that have been fetched but not yet sent on to execution. The count grows with each fetch and shrinks on dispatch and on flush. In its default mode the block gives the whole fetch width to the eligible thread that holds the fewest such instructions. Threads that run quickly are favoured this way, and a thread stalled on long-latency work cannot fill the shared window.

Picking purely by occupancy can leave a busy thread waiting for a long time. To prevent this, a per-thread wait counter forces a thread to be granted once it has stayed eligible and unselected for a programmable number of cycles. Three rotating modes share the same pointer. The first gives the full width to one thread per cycle. The second gives half the width to each of two threads. The third gives a quarter of the width to each of four threads.

The fetch unit drives the per-thread fetched, dispatched and flushed counts and the eligibility mask. It reads back the grant mask, the per-thread slot counts, the lead thread and the occupancy counts.

Top module: `smt_fetch_sel`

## Requirements
- R1: On each clock edge a thread's occupancy count becomes old count + fetched − dispatched − flushed, with all three applied in the same cycle.
- R2: The occupancy count never goes below zero (a larger decrement leaves 0) and never exceeds 2^CNT_W−1 (a larger result leaves 2^CNT_W−1).
- R3: In occupancy mode (mode_i = 0), exactly one eligible thread is granted when any thread is eligible. It is the thread with the smallest count, and its slot field equals FETCH_WIDTH.
- R4: Ties are broken by a rotating pointer. Candidates are searched starting at the pointer. After any cycle with a grant, the pointer moves to one past the last thread granted in that search order.
- R5: In occupancy mode with starve_lim_i ≠ 0, a thread that has stayed eligible and ungranted for starve_lim_i consecutive cycles is granted next, whatever its count. Ineligibility or a grant clears its wait.
- R6: In rotate mode (mode_i = 1), the first eligible thread at or after the pointer is granted with FETCH_WIDTH slots.
- R7: In pair mode (mode_i = 2), up to two eligible threads are granted, taken in pointer order, each with FETCH_WIDTH/2 slots.
- R8: In quad mode (mode_i = 3), up to four eligible threads are granted, taken in pointer order, each with FETCH_WIDTH/4 slots.
- R9: A thread whose elig_i bit is 0 is never granted, and its slot field is 0. With no eligible thread, grant_o and slots_o are all zero.
- R10: sel_valid_o is 1 exactly when some thread is granted. sel_tid_o names the first granted thread in pointer order.
- R11: Reset clears all occupancy counts and wait counters and places the pointer at thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 occupancy, 1 rotate, 2 pair, 3 quad |
| elig_i | input | NUM_THREADS | Per-thread eligibility |
| starve_lim_i | input | WAIT_W | Forced-grant wait limit, 0 disables |
| fetch_cnt_i | input | NUM_THREADS*BUS_W | Instructions fetched per thread this cycle |
| disp_cnt_i | input | NUM_THREADS*BUS_W | Instructions dispatched per thread this cycle |
| flush_cnt_i | input | NUM_THREADS*BUS_W | Instructions flushed per thread this cycle |
| grant_o | output | NUM_THREADS | Threads allowed to fetch this cycle |
| slots_o | output | NUM_THREADS*BUS_W | Fetch slots per thread |
| sel_tid_o | output | log2(NUM_THREADS) | Lead granted thread |
| sel_valid_o | output | 1 | Some thread is granted |
| icount_o | output | NUM_THREADS*CNT_W | Occupancy count per thread |

## Verification
The hardest case to reach is the forced grant. It only appears when one thread keeps a strictly lower count than a second eligible thread for several cycles in a row, so that the second one's wait reaches the limit. The bench first loads one thread's count through fetch inputs while no thread is eligible, so no wait builds up. It then makes that thread and an empty one eligible with a small limit. It checks that the empty thread wins for exactly the limit number of cycles and that the loaded thread wins on the next cycle. Saturation at the top of the count range is reached by fetching the full width for several cycles in a row.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
   typedef enum logic [1:0] {
      FM_ICOUNT = 2'd0,
      FM_ROTATE = 2'd1,
      FM_PAIR   = 2'd2,
      FM_QUAD   = 2'd3
   } fetch_mode_e;
endpackage

// File: rtl/sfs_occ_ctr.sv
// Saturating occupancy counter: one increment and two decrements per cycle.
module sfs_occ_ctr #(
   parameter int CNT_W = 6,
   parameter int BUS_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] add_i,
   input  logic [BUS_W-1:0] sub_a_i,
   input  logic [BUS_W-1:0] sub_b_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam int SUM_W = CNT_W + 2;
   localparam logic [SUM_W-1:0] MAX_S = {2'b00, {CNT_W{1'b1}}};

   logic [SUM_W-1:0] up, down, diff;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      up   = SUM_W'(cnt_o) + SUM_W'(add_i);
      down = SUM_W'(sub_a_i) + SUM_W'(sub_b_i);
      diff = up - down;
      if (down >= up)
         nxt = '0;
      else if (diff > MAX_S)
         nxt = {CNT_W{1'b1}};
      else
         nxt = diff[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= nxt;
   end
endmodule

// File: rtl/sfs_wait_ctr.sv
// Counts consecutive cycles a thread is eligible but not granted.
module sfs_wait_ctr #(
   parameter int WAIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              elig_i,
   input  logic              grant_i,
   output logic [WAIT_W-1:0] wait_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)                wait_o <= '0;
      else if (!elig_i || grant_i) wait_o <= '0;
      else if (wait_o != '1)     wait_o <= wait_o + 1'b1;
   end
endmodule

// File: rtl/sfs_picker.sv
// Combinational thread choice for all four modes.
module sfs_picker
   import sfs_pkg::*;
#(
   parameter int N      = 4,
   parameter int CNT_W  = 6,
   parameter int SLOT_W = 4,
   parameter int FW     = 8
) (
   input  fetch_mode_e          mode_i,
   input  logic [N-1:0]         elig_i,
   input  logic [N-1:0]         starve_i,
   input  logic [N*CNT_W-1:0]   cnt_i,
   input  logic [$clog2(N)-1:0] ptr_i,
   output logic [N-1:0]         grant_o,
   output logic [N*SLOT_W-1:0]  slots_o,
   output logic [$clog2(N)-1:0] lead_o,
   output logic                 valid_o,
   output logic [$clog2(N)-1:0] nxt_ptr_o
);
   localparam int TID_W = $clog2(N);

   logic [TID_W-1:0] ord   [N];
   logic [CNT_W-1:0] cnt_a [N];

   for (genvar i = 0; i < N; i++) begin : g_ord
      assign ord[i]   = ptr_i + TID_W'(i);
      assign cnt_a[i] = cnt_i[i*CNT_W +: CNT_W];
   end

   logic             hit;
   logic [TID_W-1:0] pick, last;
   logic [CNT_W-1:0] best;
   logic [2:0]       quota, taken;
   logic [SLOT_W-1:0] share;

   always_comb begin
      grant_o = '0;
      lead_o  = '0;
      hit     = 1'b0;
      pick    = ptr_i;
      last    = ptr_i;
      best    = '0;
      taken   = '0;
      quota   = 3'd1;
      share   = SLOT_W'(FW);
      case (mode_i)
         FM_PAIR: begin quota = 3'd2; share = SLOT_W'(FW/2); end
         FM_QUAD: begin quota = 3'd4; share = SLOT_W'(FW/4); end
         default: begin quota = 3'd1; share = SLOT_W'(FW);   end
      endcase

      if (mode_i == FM_ICOUNT) begin
         // forced grant for a starving thread wins first
         for (int j = 0; j < N; j++) begin
            if (!hit && elig_i[ord[j]] && starve_i[ord[j]]) begin
               hit  = 1'b1;
               pick = ord[j];
            end
         end
         if (!hit) begin
            for (int j = 0; j < N; j++) begin
               if (elig_i[ord[j]] && (!hit || cnt_a[ord[j]] < best)) begin
                  hit  = 1'b1;
                  best = cnt_a[ord[j]];
                  pick = ord[j];
               end
            end
         end
         if (hit) begin
            grant_o[pick] = 1'b1;
            lead_o        = pick;
            last          = pick;
         end
      end else begin
         for (int j = 0; j < N; j++) begin
            if (elig_i[ord[j]] && taken < quota) begin
               grant_o[ord[j]] = 1'b1;
               if (taken == 3'd0) lead_o = ord[j];
               last  = ord[j];
               taken = taken + 3'd1;
            end
         end
      end
   end

   assign valid_o   = |grant_o;
   assign nxt_ptr_o = valid_o ? last + 1'b1 : ptr_i;

   for (genvar t = 0; t < N; t++) begin : g_slot
      assign slots_o[t*SLOT_W +: SLOT_W] = grant_o[t] ? share : '0;
   end
endmodule

// File: rtl/smt_fetch_sel.sv
module smt_fetch_sel
   import sfs_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int FETCH_WIDTH = 8,
   parameter int CNT_W       = 6,
   parameter int WAIT_W      = 8
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic [1:0]                                  mode_i,
   input  logic [NUM_THREADS-1:0]                      elig_i,
   input  logic [WAIT_W-1:0]                           starve_lim_i,
   input  logic [NUM_THREADS*$clog2(FETCH_WIDTH+1)-1:0] fetch_cnt_i,
   input  logic [NUM_THREADS*$clog2(FETCH_WIDTH+1)-1:0] disp_cnt_i,
   input  logic [NUM_THREADS*$clog2(FETCH_WIDTH+1)-1:0] flush_cnt_i,
   output logic [NUM_THREADS-1:0]                      grant_o,
   output logic [NUM_THREADS*$clog2(FETCH_WIDTH+1)-1:0] slots_o,
   output logic [$clog2(NUM_THREADS)-1:0]              sel_tid_o,
   output logic                                        sel_valid_o,
   output logic [NUM_THREADS*CNT_W-1:0]                icount_o
);
   localparam int BUS_W = $clog2(FETCH_WIDTH + 1);
   localparam int TID_W = $clog2(NUM_THREADS);

   if (NUM_THREADS < 2 || (NUM_THREADS & (NUM_THREADS - 1)) != 0) begin : g_bad_n
      $error("NUM_THREADS must be a power of two of at least 2");
   end
   if (FETCH_WIDTH < 4 || FETCH_WIDTH % 4 != 0) begin : g_bad_fw
      $error("FETCH_WIDTH must be a positive multiple of 4");
   end
   if (BUS_W > CNT_W) begin : g_bad_cnt
      $error("CNT_W must hold at least one full fetch group");
   end
   if (WAIT_W < 1) begin : g_bad_wait
      $error("WAIT_W must be positive");
   end

   fetch_mode_e            mode;
   logic [TID_W-1:0]       ptr_q, nxt_ptr;
   logic [NUM_THREADS-1:0] starving;

   assign mode = fetch_mode_e'(mode_i);

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic [WAIT_W-1:0] wait_cnt;

      sfs_occ_ctr #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_occ (
         .clk     (clk),
         .rst_n   (rst_n),
         .add_i   (fetch_cnt_i[t*BUS_W +: BUS_W]),
         .sub_a_i (disp_cnt_i[t*BUS_W +: BUS_W]),
         .sub_b_i (flush_cnt_i[t*BUS_W +: BUS_W]),
         .cnt_o   (icount_o[t*CNT_W +: CNT_W])
      );

      sfs_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
         .clk     (clk),
         .rst_n   (rst_n),
         .elig_i  (elig_i[t]),
         .grant_i (grant_o[t]),
         .wait_o  (wait_cnt)
      );

      assign starving[t] = (starve_lim_i != '0) && (wait_cnt >= starve_lim_i);
   end

   sfs_picker #(
      .N      (NUM_THREADS),
      .CNT_W  (CNT_W),
      .SLOT_W (BUS_W),
      .FW     (FETCH_WIDTH)
   ) u_pick (
      .mode_i    (mode),
      .elig_i    (elig_i),
      .starve_i  (starving),
      .cnt_i     (icount_o),
      .ptr_i     (ptr_q),
      .grant_o   (grant_o),
      .slots_o   (slots_o),
      .lead_o    (sel_tid_o),
      .valid_o   (sel_valid_o),
      .nxt_ptr_o (nxt_ptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= nxt_ptr;
   end
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
   parameter int N     = 4,
   parameter int CNT_W = 6,
   parameter int BUS_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           mode,
   input logic [N-1:0]         elig,
   input logic [N*BUS_W-1:0]   fetch,
   input logic [N*BUS_W-1:0]   disp,
   input logic [N*BUS_W-1:0]   flush,
   input logic [N-1:0]         grant,
   input logic [$clog2(N)-1:0] lead,
   input logic                 valid,
   input logic [N*CNT_W-1:0]   icount
);
   AST_GRANT_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~elig) == '0);                                            // R9
   AST_VALID_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      valid == (grant != '0));                                           // R10
   AST_LEAD_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> grant[lead]);                                            // R10
   AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode < 2'd2) |-> $onehot0(grant));                                // R3
   AST_SINGLE_WHEN_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && elig != '0) |-> grant != '0);                     // R3
   AST_PAIR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2) |-> $countones(grant) <= 2);                        // R7

   for (genvar t = 0; t < N; t++) begin : g_cnt
      AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (icount[t*CNT_W +: CNT_W] == '1 && fetch[t*BUS_W +: BUS_W] != '0 &&
          disp[t*BUS_W +: BUS_W] == '0 && flush[t*BUS_W +: BUS_W] == '0)
         |=> icount[t*CNT_W +: CNT_W] == '1);                            // R2
      AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (icount[t*CNT_W +: CNT_W] == '0 && fetch[t*BUS_W +: BUS_W] == '0)
         |=> icount[t*CNT_W +: CNT_W] == '0);                            // R2
   end
endmodule

bind smt_fetch_sel sfs_checker #(
   .N     (NUM_THREADS),
   .CNT_W (CNT_W),
   .BUS_W (BUS_W)
) u_sfs_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mode   (mode_i),
   .elig   (elig_i),
   .fetch  (fetch_cnt_i),
   .disp   (disp_cnt_i),
   .flush  (flush_cnt_i),
   .grant  (grant_o),
   .lead   (sel_tid_o),
   .valid  (sel_valid_o),
   .icount (icount_o)
);

// File: tb/smt_fetch_sel_bench.sv
`timescale 1ns/1ps
module smt_fetch_sel_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [3:0]  el = 4'h0;
   logic [7:0]  lim = 8'd0;
   logic [3:0]  f [4];
   logic [3:0]  d [4];
   logic [3:0]  x [4];
   logic [15:0] fetch_v, disp_v, flush_v;
   logic [3:0]  grant;
   logic [15:0] slots;
   logic [1:0]  lead;
   logic        valid;
   logic [23:0] icount;
   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 4; i++) begin
         fetch_v[i*4 +: 4] = f[i];
         disp_v[i*4 +: 4]  = d[i];
         flush_v[i*4 +: 4] = x[i];
      end
   end

   smt_fetch_sel u_smt_fetch_sel (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_i       (mode),
      .elig_i       (el),
      .starve_lim_i (lim),
      .fetch_cnt_i  (fetch_v),
      .disp_cnt_i   (disp_v),
      .flush_cnt_i  (flush_v),
      .grant_o      (grant),
      .slots_o      (slots),
      .sel_tid_o    (lead),
      .sel_valid_o  (valid),
      .icount_o     (icount)
   );

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic clear_in();
      for (int i = 0; i < 4; i++) begin f[i] = '0; d[i] = '0; x[i] = '0; end
   endtask

   task automatic expect_sel(string tag, logic [3:0] g, int share, int ld);
      chk(tag, "grant", grant, g);
      chk(tag, "valid", valid, (g != 0));
      for (int t = 0; t < 4; t++)
         chk(tag, "slots", slots[t*4 +: 4], g[t] ? share : 0);
      if (g != 0) chk(tag, "lead", lead, ld);
   endtask

   task automatic expect_cnt(string tag, int t, int exp);
      chk(tag, "icount", icount[t*6 +: 6], exp);
   endtask

   task automatic t_reset();
      for (int t = 0; t < 4; t++) expect_cnt("R11", t, 0);
      expect_sel("R9", 4'h0, 0, 0);
      mode = 2'd1; el = 4'hF; #1;
      expect_sel("R11", 4'b0001, 8, 0);
      el = 4'h0; mode = 2'd0; #1;
   endtask

   task automatic t_count();
      f[0] = 1; f[1] = 2; f[2] = 3; f[3] = 4;
      step(); clear_in();
      for (int t = 0; t < 4; t++) expect_cnt("R1", t, t + 1);
      f[0] = 3; d[0] = 1; x[0] = 1;
      step(); clear_in();
      expect_cnt("R1", 0, 2);
      d[1] = 5;
      step(); clear_in();
      expect_cnt("R2", 1, 0);
      f[3] = 8;
      repeat (8) step();
      clear_in();
      expect_cnt("R2", 3, 63);
      f[3] = 8; d[3] = 1;
      step(); clear_in();
      expect_cnt("R2", 3, 63);
   endtask

   task automatic t_icount();
      mode = 2'd0; el = 4'hF; #1;
      expect_sel("R3", 4'b0010, 8, 1);
      step();
      el = 4'b1101; #1;
      expect_sel("R3", 4'b0001, 8, 0);
      step();
   endtask

   task automatic t_tie();
      el = 4'h0;
      for (int i = 0; i < 4; i++) begin d[i] = 15; x[i] = 15; end
      repeat (3) step();
      clear_in();
      for (int t = 0; t < 4; t++) expect_cnt("R2", t, 0);
      el = 4'hF; #1;
      expect_sel("R4", 4'b0010, 8, 1);
      step(); expect_sel("R4", 4'b0100, 8, 2);
      step(); expect_sel("R4", 4'b1000, 8, 3);
      step(); expect_sel("R4", 4'b0001, 8, 0);
      step();
   endtask

   task automatic t_starve();
      el = 4'h0; f[0] = 5;
      step(); clear_in();
      lim = 8'd3; el = 4'b0011; #1;
      expect_sel("R5", 4'b0010, 8, 1);
      step(); expect_sel("R5", 4'b0010, 8, 1);
      step(); expect_sel("R5", 4'b0010, 8, 1);
      step(); expect_sel("R5", 4'b0001, 8, 0);
      step(); expect_sel("R5", 4'b0010, 8, 1);
      step();
      lim = 8'd0;
   endtask

   task automatic t_rotate();
      mode = 2'd1; el = 4'hF; #1;
      expect_sel("R6", 4'b0100, 8, 2);
      step(); expect_sel("R6", 4'b1000, 8, 3);
      step(); expect_sel("R6", 4'b0001, 8, 0);
      step(); expect_sel("R6", 4'b0010, 8, 1);
      step();
      el = 4'b1010; #1;
      expect_sel("R6", 4'b1000, 8, 3);
      step(); expect_sel("R9", 4'b0010, 8, 1);
      step(); expect_sel("R6", 4'b1000, 8, 3);
      step();
   endtask

   task automatic t_pair();
      mode = 2'd2; el = 4'hF; #1;
      expect_sel("R7", 4'b0011, 4, 0);
      step(); expect_sel("R7", 4'b1100, 4, 2);
      step();
      el = 4'b0100; #1;
      expect_sel("R7", 4'b0100, 4, 2);
      step();
   endtask

   task automatic t_quad();
      mode = 2'd3; el = 4'hF; #1;
      expect_sel("R8", 4'b1111, 2, 3);
      step();
      el = 4'b1001; #1;
      expect_sel("R8", 4'b1001, 2, 3);
      step();
   endtask

   task automatic t_none();
      mode = 2'd0; el = 4'h0; #1;
      expect_sel("R9", 4'h0, 0, 0);
      chk("R10", "valid", valid, 0);
      mode = 2'd3; #1;
      expect_sel("R9", 4'h0, 0, 0);
   endtask

   initial begin
      clear_in();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_count();
      t_icount();
      t_tie();
      t_starve();
      t_rotate();
      t_pair();
      t_quad();
      t_none();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule